// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This block holds two independent down-counters behind one small 32-bit register port. Each counter has a reload register and a live count register. It decrements by one on every clock cycle in which the reference `tick` input is high and the counter is enabled. When an enabled counter already sits at zero on a tick, it raises its interrupt line for exactly one clock cycle. If its auto-reload bit is set, it refills from its reload register on that tick. If not, it drops its own enable bit and stays at zero.

Both channels share one control word, and each channel has one enable bit and one auto-reload bit in it. A periodic interval of N ticks comes from writing N-1 into both the reload and count registers and then setting both bits. A one-shot event comes from writing a delay D (1 to 0xFFFFFFFE) into the count register and setting only the enable bit. The interrupt then fires on tick D+1. The bus is a plain register port: a write strobe with a word address and data, and a read data bus that follows the address combinationally. The port has no handshake, since every access completes in one cycle.

Top module: `dual_reload_timer`

## Requirements
- R1: A synchronous active-high `rst` clears both enable bits, both auto-reload bits, both reload registers and both count registers, and drives both interrupt lines low.
- R2: The control word sits at word address 0. Bit 0 is the channel 0 enable and bit 1 is the channel 0 auto-reload. Bit 2 is the channel 1 enable and bit 3 is the channel 1 auto-reload. Bits 31:4 read as zero.
- R3: Word address 4 is the channel 0 reload and address 5 is the channel 0 count. Address 6 is the channel 1 reload and address 7 is the channel 1 count. Each reads back its current contents.
- R4: An enabled channel decrements its count by one on each cycle with `tick` high and holds it when `tick` is low. Starting from all ones, the count reads as a falling value.
- R5: An enabled channel whose count is zero on a tick drives its `irq` bit high for exactly the following clock cycle.
- R6: With auto-reload set, the zero tick loads the reload value, so a reload of N-1 yields one interrupt every N ticks.
- R7: With auto-reload clear, the zero tick clears that channel's enable bit in the control word, and the count then stays at zero with no further interrupts.
- R8: A disabled channel holds its count regardless of `tick`.
- R9: A bus write to a count register in the same cycle as a tick wins over counting, and it also suppresses that cycle's zero-crossing interrupt.
- R10: Word addresses 1, 2 and 3 read as zero, and writes to them change no register.
- R11: The two channels are independent: activity on one never changes the other's count or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick enable, one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | One-cycle interrupt pulses, bit i for channel i |

## Verification
The bench targets the zero crossing from several angles. A one-shot that fails to clear its enable would keep firing every tick after expiry. A one-cycle pulse held too long shows as a stuck `irq`. An off-by-one in reload would give a period of N+1 instead of N, which changes the interrupt count over fifteen ticks. It also writes a count register in the same cycle as a tick: a design that lets counting win would show 49 instead of 50, or would raise a spurious interrupt from a count of zero. It writes to the unmapped addresses and reads neighbouring registers back, so a decoder that aliases would corrupt them. Finally, a channel is left idle while its neighbour runs, to catch shared-enable mistakes.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;

  function automatic logic [ADDR_W-1:0] reload_addr(input int ch);
    return ADDR_W'(4 + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] count_addr(input int ch);
    return ADDR_W'(5 + 2 * ch);
  endfunction
endpackage

// File: rtl/dtmr_regif.sv
module dtmr_regif
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       ch_rl,
  input  logic [NUM_CH*CNT_W-1:0] ch_reload,
  input  logic [NUM_CH*CNT_W-1:0] ch_count,
  output logic                    ctrl_we,
  output logic [NUM_CH-1:0]       reload_we,
  output logic [NUM_CH-1:0]       count_we,
  output logic [DATA_W-1:0]       bus_rdata
);
  assign ctrl_we = bus_we && (bus_addr == A_CTRL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign reload_we[c] = bus_we && (bus_addr == reload_addr(c));
    assign count_we[c]  = bus_we && (bus_addr == count_addr(c));
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == A_CTRL) begin
        bus_rdata[2*c]   = ch_en[c];
        bus_rdata[2*c+1] = ch_rl[c];
      end
      if (bus_addr == reload_addr(c))
        bus_rdata = DATA_W'(ch_reload[c*CNT_W +: CNT_W]);
      if (bus_addr == count_addr(c))
        bus_rdata = DATA_W'(ch_count[c*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic             en_wr,
  input  logic             rl_wr,
  input  logic             reload_we,
  input  logic             count_we,
  input  logic [CNT_W-1:0] wr_val,
  output logic             en,
  output logic             rl,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic at_zero, step, fire;

  assign at_zero = (count == '0);
  assign step    = en && tick && !count_we;
  assign fire    = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      rl     <= 1'b0;
      reload <= '0;
      count  <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= fire;
      if (reload_we) reload <= wr_val;
      if (count_we)
        count <= wr_val;
      else if (step)
        count <= at_zero ? (rl ? reload : count) : count - CNT_W'(1);
      if (ctrl_we) begin
        en <= en_wr;
        rl <= rl_wr;
      end else if (fire && !rl) begin
        en <= 1'b0;
      end
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !count_we && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en && tick && !count_we && count == '0));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !count_we && count == '0 && rl) |=> (count == $past(reload)));

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !count_we && count == '0 && !rl && !ctrl_we) |=> (!en && count == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !count_we) |=> (count == $past(count)));

  assert_wr_priority_R9: assert property (@(posedge clk) disable iff (rst)
    count_we |=> (count == $past(wr_val) && !irq));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic                    ctrl_we;
  logic [NUM_CH-1:0]       reload_we, count_we, ch_en, ch_rl;
  logic [NUM_CH*CNT_W-1:0] ch_reload, ch_count;

  dtmr_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .ch_en     (ch_en),
    .ch_rl     (ch_rl),
    .ch_reload (ch_reload),
    .ch_count  (ch_count),
    .ctrl_we   (ctrl_we),
    .reload_we (reload_we),
    .count_we  (count_we),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dtmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .ctrl_we   (ctrl_we),
      .en_wr     (bus_wdata[2*c]),
      .rl_wr     (bus_wdata[2*c+1]),
      .reload_we (reload_we[c]),
      .count_we  (count_we[c]),
      .wr_val    (bus_wdata[CNT_W-1:0]),
      .en        (ch_en[c]),
      .rl        (ch_rl[c]),
      .reload    (ch_reload[c*CNT_W +: CNT_W]),
      .count     (ch_count[c*CNT_W +: CNT_W]),
      .irq       (irq[c])
    );
  end

  assert_irq_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0));
endmodule

// File: tb/sim_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  int cnt0 = 0;
  int cnt1 = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dual_reload_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq[0]) cnt0++;
    if (irq[1]) cnt1++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{3'd4, 32'h1234_5678, 32'h1234_5678},
    '{3'd6, 32'hCAFE_F00D, 32'hCAFE_F00D},
    '{3'd5, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{3'd7, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    '{3'd1, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd2, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd3, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd0, 32'hFFFF_FFFA, 32'h0000_000A},
    '{3'd0, 32'h0000_0005, 32'h0000_0005},
    '{3'd0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {30'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register cleared", v, 32'd0);
    end

    // R2/R3/R10 table of write then read-back vectors
    for (int i = 0; i < 10; i++) begin
      wr(TBL[i].a, TBL[i].w);
      rd(TBL[i].a, v);
      chk("R2/R3/R10 table readback", v, TBL[i].e);
    end
    rd(3'd5, v); chk("R10 unmapped write left count0", v, 32'hA5A5_A5A5);
    rd(3'd7, v); chk("R10 unmapped write left count1", v, 32'h0F0F_0F0F);
    rd(3'd4, v); chk("R10 unmapped write left reload0", v, 32'h1234_5678);

    // R4 count down and hold when tick low
    wr(3'd5, 32'd10);
    wr(3'd0, 32'h1);
    tick_n(3);
    rd(3'd5, v); chk("R4 three ticks", v, 32'd7);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R4 hold with tick low", v, 32'd7);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd0, 32'h3);
    tick_n(5);
    rd(3'd5, v); chk("R4 free-running from all ones", v, 32'hFFFF_FFFA);

    // R5 and R7 one-shot expiry
    wr(3'd5, 32'd2);
    wr(3'd0, 32'h1);
    tick_n(2);
    rd(3'd5, v); chk("R5 count reached zero", v, 32'd0);
    chk("R5 no irq before zero tick", {30'd0, irq}, 32'd0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R5 irq pulse on zero tick", {30'd0, irq}, 32'd1);
    rd(3'd0, v); chk("R7 one-shot cleared enable", v, 32'd0);
    @(negedge clk);
    chk("R5 irq lasts one cycle", {30'd0, irq}, 32'd0);
    cnt0 = 0;
    tick_n(4);
    @(negedge clk);
    rd(3'd5, v); chk("R7 stays at zero", v, 32'd0);
    chk("R7 no further irq", cnt0, 0);

    // R6 periodic on channel 1, R8/R11 channel 0 idle
    wr(3'd5, 32'd100);
    wr(3'd6, 32'd4);
    wr(3'd7, 32'd4);
    cnt0 = 0; cnt1 = 0;
    wr(3'd0, 32'hC);
    tick_n(15);
    @(negedge clk);
    chk("R6 three periods of five ticks", cnt1, 3);
    rd(3'd7, v); chk("R6 reloaded value", v, 32'd4);
    rd(3'd0, v); chk("R6 periodic keeps enable", v, 32'hC);
    rd(3'd5, v); chk("R8 disabled channel held", v, 32'd100);
    chk("R11 idle channel no irq", cnt0, 0);

    // R9 count write beats tick, and suppresses expiry
    wr(3'd7, 32'd0);
    cnt1 = 0;
    bus_we = 1'b1; bus_addr = 3'd7; bus_wdata = 32'd9; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    chk("R9 no irq when write meets zero tick", {30'd0, irq}, 32'd0);
    rd(3'd7, v); chk("R9 written value kept", v, 32'd9);
    bus_we = 1'b1; bus_addr = 3'd7; bus_wdata = 32'd50; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    rd(3'd7, v); chk("R9 write wins over decrement", v, 32'd50);
    chk("R9 no irq counted", cnt1, 0);

    // R1 reset while running
    tick = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tick = 1'b0;
    chk("R1 irq low after reset", {30'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 cleared after running", v, 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule